// File: doc/BRIEF.md
# JTAG Indirect Register Access Host Sequencer

This block sits on the debugger side of a JTAG link. It produces TCK, TMS and TDI and samples TDO so that a single indirect register read or write takes place on a target TAP. A command carries four things: a read/write selector, the instruction code that selects the target data register, the register width (1 to 18 bits) and the write data. Each command starts with one instruction scan. A short data-register scan then starts the operation. Single-bit polls of the target's Busy flag follow. For a read, a final scan fetches the result. The sequencer reports completion with a one-cycle pulse that carries the read data and a timeout flag.

Every data-register scan is only as long as it needs to be. The 20-bit target frame holds the busy flag in bit 0, the read data in bits 18:1 and a two-bit opcode in bits 19:18, where 10 means read, 11 means write, and a 0 in bit 19 means poll. Bits shifted in last land at the top of the frame. A read start is therefore 2 bits long, a write start is width+2 bits, a poll is 1 bit, and a fetch is width+1 bits. TCK is a free-running divided copy of the system clock.

Top module: `jtag_indirect_host`

## Requirements
- R1: After reset, tck, tms, tdi, rsp_done and rsp_timeout are 0 and idle is 1.
- R2: tck stays high for DIV clk cycles, then low for DIV clk cycles. tms and tdi change only in the clk cycle in which tck falls. Any TDO sample is taken as tck rises.
- R3: Every accepted command begins with exactly one instruction scan of IR_LEN bits, sent least significant bit first. The scan goes from Run-Test/Idle through Select-DR, Select-IR, Capture-IR and Shift-IR, then back through Exit1-IR and Update-IR to Run-Test/Idle.
- R4: A read starts with a 2-bit data scan that shifts 0 and then 1, so opcode 10 lands in frame bits 19:18.
- R5: A write starts with a data scan of width+2 bits. It shifts the width data bits least significant bit first, then 1 and 1. This leaves the data left-justified with its MSB in frame bit 17 and opcode 11 in bits 19:18.
- R6: After the start scan, the block repeats 1-bit data scans with TDI 0 until the captured TDO bit, which is the Busy flag, reads 0.
- R7: Once Busy is 0 after a read, one data scan of width+1 bits with TDI 0 fetches the result. The first captured bit is Busy and the next width bits are the data, least significant bit first. rsp_rdata returns the data right-justified with the upper bits at zero.
- R8: Between the start scan and completion, no instruction scan occurs. A write ends after the poll that reads 0, with no fetch scan.
- R9: If POLL_MAX polls in a row all read Busy as 1, the command ends with rsp_timeout=1 and rsp_rdata=0, and no fetch scan takes place.
- R10: rsp_done is high for exactly one cycle per command and idle returns high in the next cycle. cmd_valid has no effect while idle is 0.
- R11: While idle is 1, tms is 0 so that the target stays in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when idle is 1 |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ir | input | IR_LEN | Instruction code selecting the target register |
| cmd_width | input | 5 | Register width, 1 to 18 |
| cmd_wdata | input | 18 | Write data, right-justified |
| idle | output | 1 | Sequencer ready for a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 18 | Read result, right-justified |
| rsp_timeout | output | 1 | Poll limit reached on the last command |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The assertions assume three things. First, cmd_width lies between 1 and 18 whenever a command is offered while idle is 1. Second, tdo comes from a TAP that changes it only on falling tck. Third, the target honours the frame layout, so Busy always arrives first in a scan. The bench keeps within these limits by using a behavioural TAP model that updates TDO on the falling edge and by using only widths of 1, 8 and 18. A watched monitor confirms that TMS and TDI move only at tck falls and that TMS stays low between commands.

// File: rtl/jih_pkg.sv
package jih_pkg;
  localparam int JIH_DATA_W  = 18;
  localparam int JIH_FRAME_W = 20;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_IR,
    SQ_START,
    SQ_POLL,
    SQ_FETCH,
    SQ_FIN
  } sq_state_e;
endpackage

// File: rtl/jih_tck_div.sv
module jih_tck_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tck,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tck_q, tck_n;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(DIV - 1));
    cnt_n = wrap ? '0 : cnt_q + CW'(1);
    tck_n = wrap ? ~tck_q : tck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tck_q <= tck_n;
    end
  end

  assign tck  = tck_q;
  assign rise = wrap & ~tck_q;
  assign fall = wrap & tck_q;
endmodule

// File: rtl/jih_scan_engine.sv
module jih_scan_engine #(
  parameter int SW = 20,
  parameter int LW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          start,
  input  logic          is_ir,
  input  logic [LW-1:0] len,
  input  logic [SW-1:0] data,
  input  logic          tdo,
  output logic          tms,
  output logic          tdi,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] cap
);
  localparam int PW = $clog2(SW + 7);
  localparam int IW = $clog2(SW);

  logic          act_q, act_n, drv_q, drv_n, ir_q, ir_n, done_q, done_n;
  logic          tms_q, tms_n, tdi_q, tdi_n;
  logic [PW-1:0] pos_q, pos_n;
  logic [LW-1:0] len_q, len_n;
  logic [SW-1:0] dat_q, dat_n, cap_q, cap_n;
  logic [PW-1:0] pre, end_sh, last;
  logic [IW-1:0] idx;
  logic          in_sh, tms_v, tdi_v;

  always_comb begin
    pre    = ir_q ? PW'(4) : PW'(3);
    end_sh = pre + PW'(len_q);
    last   = end_sh + PW'(1);
    in_sh  = (pos_q >= pre) && (pos_q < end_sh);
    idx    = IW'(pos_q - pre);
    if (pos_q < pre)       tms_v = (pos_q == '0) || (ir_q && pos_q == PW'(1));
    else if (in_sh)        tms_v = (pos_q == end_sh - PW'(1));
    else                   tms_v = (pos_q == end_sh);
    tdi_v  = in_sh ? dat_q[idx] : 1'b0;
  end

  always_comb begin
    act_n = act_q; drv_n = drv_q; ir_n = ir_q; pos_n = pos_q;
    len_n = len_q; dat_n = dat_q; cap_n = cap_q;
    tms_n = tms_q; tdi_n = tdi_q; done_n = 1'b0;
    if (start && !act_q) begin
      act_n = 1'b1; drv_n = 1'b0; pos_n = '0;
      ir_n  = is_ir; len_n = len; dat_n = data; cap_n = '0;
    end else if (act_q) begin
      if (fall && !drv_q) begin
        tms_n = tms_v;
        tdi_n = tdi_v;
        drv_n = 1'b1;
      end
      if (rise && drv_q) begin
        if (in_sh) cap_n[idx] = tdo;
        drv_n = 1'b0;
        if (pos_q == last) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          pos_n = pos_q + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; drv_q <= 1'b0; ir_q <= 1'b0; done_q <= 1'b0;
      tms_q <= 1'b0; tdi_q <= 1'b0; pos_q <= '0; len_q <= '0;
      dat_q <= '0;   cap_q <= '0;
    end else begin
      act_q <= act_n; drv_q <= drv_n; ir_q <= ir_n; done_q <= done_n;
      tms_q <= tms_n; tdi_q <= tdi_n; pos_q <= pos_n; len_q <= len_n;
      dat_q <= dat_n; cap_q <= cap_n;
    end
  end

  assign tms  = tms_q;
  assign tdi  = tdi_q;
  assign busy = act_q;
  assign done = done_q;
  assign cap  = cap_q;

  assert_pins_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(tms) && $stable(tdi)));

  assert_start_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);
endmodule

// File: rtl/jih_sequencer.sv
module jih_sequencer import jih_pkg::*; #(
  parameter int IR_LEN   = 8,
  parameter int POLL_MAX = 64,
  parameter int SW       = 20,
  parameter int LW       = $clog2(SW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [IR_LEN-1:0]     cmd_ir,
  input  logic [4:0]            cmd_width,
  input  logic [JIH_DATA_W-1:0] cmd_wdata,
  output logic                  idle,
  output logic                  rsp_done,
  output logic [JIH_DATA_W-1:0] rsp_rdata,
  output logic                  rsp_timeout,
  output logic                  sc_start,
  output logic                  sc_is_ir,
  output logic [LW-1:0]         sc_len,
  output logic [SW-1:0]         sc_data,
  input  logic                  sc_done,
  input  logic [SW-1:0]         sc_cap
);
  localparam int CW = $clog2(POLL_MAX + 1);

  sq_state_e             st_q, st_n;
  logic                  lau_q, lau_n, wr_q, wr_n, to_q, to_n;
  logic [IR_LEN-1:0]     ir_q, ir_n;
  logic [4:0]            w_q, w_n;
  logic [JIH_DATA_W-1:0] wd_q, wd_n, rd_q, rd_n, mask;
  logic [CW-1:0]         pc_q, pc_n;

  always_comb begin
    mask     = (JIH_DATA_W'(1) << w_q) - JIH_DATA_W'(1);
    sc_start = !lau_q && (st_q inside {SQ_IR, SQ_START, SQ_POLL, SQ_FETCH});
    sc_is_ir = (st_q == SQ_IR);
    sc_len   = LW'(1);
    sc_data  = '0;
    case (st_q)
      SQ_IR:    begin sc_len = LW'(IR_LEN); sc_data = SW'(ir_q); end
      SQ_START: begin
        if (wr_q) begin
          sc_len  = LW'(w_q) + LW'(2);
          sc_data = SW'(wd_q & mask) | (SW'(3) << w_q);
        end else begin
          sc_len  = LW'(2);
          sc_data = SW'(2);
        end
      end
      SQ_FETCH: sc_len = LW'(w_q) + LW'(1);
      default:  sc_len = LW'(1);
    endcase
  end

  always_comb begin
    st_n = st_q; lau_n = lau_q; wr_n = wr_q; to_n = to_q; ir_n = ir_q;
    w_n = w_q; wd_n = wd_q; rd_n = rd_q; pc_n = pc_q;
    if (sc_start) lau_n = 1'b1;
    case (st_q)
      SQ_IDLE: if (cmd_valid) begin
        st_n = SQ_IR; wr_n = cmd_write; ir_n = cmd_ir; w_n = cmd_width;
        wd_n = cmd_wdata; rd_n = '0; to_n = 1'b0; lau_n = 1'b0;
      end
      SQ_IR:    if (sc_done) begin st_n = SQ_START; lau_n = 1'b0; end
      SQ_START: if (sc_done) begin st_n = SQ_POLL; lau_n = 1'b0; pc_n = '0; end
      SQ_POLL:  if (sc_done) begin
        lau_n = 1'b0;
        if (!sc_cap[0])                    st_n = wr_q ? SQ_FIN : SQ_FETCH;
        else if (pc_q == CW'(POLL_MAX - 1)) begin st_n = SQ_FIN; to_n = 1'b1; end
        else                               pc_n = pc_q + CW'(1);
      end
      SQ_FETCH: if (sc_done) begin
        st_n = SQ_FIN; lau_n = 1'b0;
        rd_n = sc_cap[JIH_DATA_W:1] & mask;
      end
      SQ_FIN:   st_n = SQ_IDLE;
      default:  st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; lau_q <= 1'b0; wr_q <= 1'b0; to_q <= 1'b0;
      ir_q <= '0; w_q <= '0; wd_q <= '0; rd_q <= '0; pc_q <= '0;
    end else begin
      st_q <= st_n; lau_q <= lau_n; wr_q <= wr_n; to_q <= to_n;
      ir_q <= ir_n; w_q <= w_n; wd_q <= wd_n; rd_q <= rd_n; pc_q <= pc_n;
    end
  end

  assign idle        = (st_q == SQ_IDLE);
  assign rsp_done    = (st_q == SQ_FIN);
  assign rsp_rdata   = rd_q;
  assign rsp_timeout = to_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && idle));

  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q < CW'(POLL_MAX));

  assert_width_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && idle) |-> (cmd_width >= 5'd1 && cmd_width <= 5'd18));

  assert_no_ir_rescan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && st_q == SQ_POLL) |=> !(sc_start && sc_is_ir));
endmodule

// File: rtl/jtag_indirect_host.sv
module jtag_indirect_host #(
  parameter int IR_LEN   = 8,
  parameter int DIV      = 4,
  parameter int POLL_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [IR_LEN-1:0] cmd_ir,
  input  logic [4:0]        cmd_width,
  input  logic [17:0]       cmd_wdata,
  output logic              idle,
  output logic              rsp_done,
  output logic [17:0]       rsp_rdata,
  output logic              rsp_timeout,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int SW = (IR_LEN > jih_pkg::JIH_FRAME_W) ? IR_LEN : jih_pkg::JIH_FRAME_W;
  localparam int LW = $clog2(SW + 1);

  logic          rise, fall, sc_start, sc_is_ir, sc_done, sc_busy;
  logic [LW-1:0] sc_len;
  logic [SW-1:0] sc_data, sc_cap;

  jih_tck_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tck(tck), .rise(rise), .fall(fall)
  );

  jih_scan_engine #(.SW(SW), .LW(LW)) u_eng (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .start(sc_start),
    .is_ir(sc_is_ir), .len(sc_len), .data(sc_data), .tdo(tdo), .tms(tms),
    .tdi(tdi), .busy(sc_busy), .done(sc_done), .cap(sc_cap)
  );

  jih_sequencer #(.IR_LEN(IR_LEN), .POLL_MAX(POLL_MAX), .SW(SW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_ir(cmd_ir), .cmd_width(cmd_width), .cmd_wdata(cmd_wdata), .idle(idle),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .sc_start(sc_start), .sc_is_ir(sc_is_ir), .sc_len(sc_len), .sc_data(sc_data),
    .sc_done(sc_done), .sc_cap(sc_cap)
  );

  assert_tms_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !tms);

  assert_engine_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sc_busy);
endmodule

// File: tb/tb_jtag_indirect_host.sv
module tb_jtag_indirect_host;
  localparam int IRL = 6;
  localparam int DIVT = 2;
  localparam int PMAX = 6;

  logic clk, rst_n, cmd_valid, cmd_write, idle, rsp_done, rsp_timeout;
  logic tck, tms, tdi, tdo;
  logic [IRL-1:0] cmd_ir;
  logic [4:0]     cmd_width;
  logic [17:0]    cmd_wdata, rsp_rdata;

  int n_chk, n_bad;

  jtag_indirect_host #(.IR_LEN(IRL), .DIV(DIVT), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_ir(cmd_ir), .cmd_width(cmd_width), .cmd_wdata(cmd_wdata), .idle(idle),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural target TAP ----------------
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIR, CIR, SHI, E1I, PIR, E2I, UIR} tap_e;
  tap_e         ts;
  logic [19:0]  sr;
  logic [31:0]  dbits, ibits;
  int           dcnt, icnt;
  int           busy_cnt, busy_n;
  logic [17:0]  tgt_val, rd_reg, wr_seen;
  logic         lg_ir [64];
  int           lg_len [64];
  logic [31:0]  lg_bits [64];
  int           n_log;

  function automatic tap_e nxt(tap_e s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;  RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;  CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;  E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;  E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;  SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;  SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;  PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;  default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ts <= RTI; sr <= '0; dcnt <= 0; icnt <= 0; n_log <= 0;
      dbits <= '0; ibits <= '0;
    end else begin
      case (ts)
        CDR: begin
          sr <= {1'b0, rd_reg, (busy_cnt > 0)};
          if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
          dcnt <= 0; dbits <= '0;
        end
        SHD: begin
          sr <= {tdi, sr[19:1]};
          dbits[dcnt] <= tdi; dcnt <= dcnt + 1;
        end
        CIR: begin icnt <= 0; ibits <= '0; end
        SHI: begin ibits[icnt] <= tdi; icnt <= icnt + 1; end
        E1D: if (tms) begin
          lg_ir[n_log] <= 1'b0; lg_len[n_log] <= dcnt; lg_bits[n_log] <= dbits;
          n_log <= n_log + 1;
          if (busy_cnt == 0 && sr[19]) begin
            busy_cnt <= busy_n;
            if (sr[18]) wr_seen <= sr[17:0];
            else        rd_reg  <= tgt_val;
          end
        end
        E1I: if (tms) begin
          lg_ir[n_log] <= 1'b1; lg_len[n_log] <= icnt; lg_bits[n_log] <= ibits;
          n_log <= n_log + 1;
        end
        default: ;
      endcase
      ts <= nxt(ts, tms);
    end
  end

  always @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else        tdo <= (ts == SHD) ? sr[0] : 1'b0;
  end

  // ---------------- pin monitors (R2, R11) ----------------
  logic prev_tck, prev_tms, prev_tdi, seen_tog;
  int   run_len, err_tck, err_pin, err_idle;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_tck <= 1'b0; prev_tms <= 1'b0; prev_tdi <= 1'b0; seen_tog <= 1'b0;
      run_len <= 0; err_tck <= 0; err_pin <= 0; err_idle <= 0;
    end else begin
      if (tck != prev_tck) begin
        if (seen_tog && run_len + 1 != DIVT) err_tck <= err_tck + 1;
        seen_tog <= 1'b1; run_len <= 0;
      end else run_len <= run_len + 1;
      if ((tms != prev_tms || tdi != prev_tdi) && !(prev_tck && !tck))
        err_pin <= err_pin + 1;
      if (idle && tms) err_idle <= err_idle + 1;
      prev_tck <= tck; prev_tms <= tms; prev_tdi <= tdi;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int done_cycles;
  task automatic run_cmd(logic wr, logic [IRL-1:0] ir, int w, logic [17:0] wd,
                         int bsy, logic [17:0] val, bit intrude);
    int guard;
    busy_n = bsy; tgt_val = val;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_ir = ir; cmd_width = 5'(w); cmd_wdata = wd;
    @(negedge clk);
    if (intrude) begin
      cmd_write = ~wr; cmd_ir = ~ir; cmd_width = 5'd18;
      repeat (10) @(negedge clk);
    end
    cmd_valid = 1'b0;
    done_cycles = 0; guard = 0;
    while (!rsp_done && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) check("watchdog", 32'd1, 32'd0);
    while (rsp_done) begin done_cycles++; @(negedge clk); end
  endtask

  task automatic test_reset();
    check("R1 tck", 32'(tck), 0);  check("R1 tms", 32'(tms), 0);
    check("R1 tdi", 32'(tdi), 0);  check("R1 idle", 32'(idle), 1);
    check("R1 done", 32'(rsp_done), 0); check("R1 timeout", 32'(rsp_timeout), 0);
  endtask

  task automatic test_read(int w, logic [17:0] v, int bsy, logic [IRL-1:0] ir);
    int base;
    base = n_log;
    run_cmd(1'b0, ir, w, '0, bsy, v, 1'b0);
    check("R7 rdata", 32'(rsp_rdata), 32'(v));
    check("R9 no timeout", 32'(rsp_timeout), 0);
    check("R10 done width", done_cycles, 1);
    check("R10 idle after", 32'(idle), 1);
    check("R3 ir first", 32'(lg_ir[base]), 1);
    check("R3 ir len", lg_len[base], IRL);
    check("R3 ir code", lg_bits[base], 32'(ir));
    check("R4 start len", lg_len[base+1], 2);
    check("R4 start bits", lg_bits[base+1], 32'h2);
    for (int k = 0; k <= bsy; k++) begin
      check("R6 poll len", lg_len[base+2+k], 1);
      check("R6 poll bit", lg_bits[base+2+k], 0);
      check("R8 poll not ir", 32'(lg_ir[base+2+k]), 0);
    end
    check("R7 fetch len", lg_len[base+3+bsy], w + 1);
    check("R7 fetch tdi", lg_bits[base+3+bsy], 0);
    check("R8 scan count", n_log - base, bsy + 4);
  endtask

  task automatic test_write(int w, logic [17:0] d, int bsy, logic [IRL-1:0] ir);
    int base;
    logic [17:0] dm;
    base = n_log;
    dm = d & ((18'h1 << w) - 18'h1);
    run_cmd(1'b1, ir, w, d, bsy, '0, 1'b0);
    check("R3 ir code", lg_bits[base], 32'(ir));
    check("R5 start len", lg_len[base+1], w + 2);
    check("R5 start bits", lg_bits[base+1], 32'(dm) | (32'h3 << w));
    check("R5 left justified", 32'(wr_seen >> (18 - w)), 32'(dm));
    check("R6 poll count", n_log - base - 2, bsy + 1);
    check("R8 no fetch", 32'(lg_len[n_log-1]), 1);
    check("R10 done width", done_cycles, 1);
  endtask

  task automatic test_timeout();
    int base;
    base = n_log;
    run_cmd(1'b0, 6'h15, 8, '0, 50, 18'h77, 1'b0);
    check("R9 timeout", 32'(rsp_timeout), 1);
    check("R9 rdata zero", 32'(rsp_rdata), 0);
    check("R9 poll count", n_log - base - 2, PMAX);
    check("R9 no fetch", 32'(lg_len[n_log-1]), 1);
    busy_cnt = 0;
  endtask

  task automatic test_ignored();
    int base;
    base = n_log;
    run_cmd(1'b0, 6'h2A, 8, '0, 5, 18'h5C, 1'b1);
    check("R10 rdata", 32'(rsp_rdata), 32'h5C);
    check("R10 single ir", lg_len[base], IRL);
    check("R10 ir code", lg_bits[base], 32'h2A);
    check("R10 scan count", n_log - base, 5 + 4);
    check("R10 done width", done_cycles, 1);
    repeat (40) @(negedge clk);
    check("R10 stays idle", 32'(idle), 1);
    check("R10 no extra scans", n_log - base, 9);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_ir = '0; cmd_width = 5'd1; cmd_wdata = '0;
    busy_cnt = 0; busy_n = 0; tgt_val = '0; rd_reg = '0; wr_seen = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_read(8, 18'hA5, 3, 6'h21);
    test_read(18, 18'h2ABCD, 0, 6'h3F);
    test_read(1, 18'h1, 1, 6'h01);
    test_write(8, 18'h3C, 2, 6'h12);
    test_write(18, 18'h35A5A, 0, 6'h0C);
    test_write(1, 18'h1, 1, 6'h33);
    test_timeout();
    test_ignored();
    check("R2 tck half period", err_tck, 0);
    check("R2 pins move on fall", err_pin, 0);
    check("R11 tms low idle", err_idle, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule